// File: doc/BRIEF.md
# Quadrature Encoder Position Decoder

This block turns the two phase signals and the index signal of an incremental rotary encoder into a signed position count. Each raw input first passes through a multi-stage synchronizer and a deglitch filter. A filtered level is accepted only after the synchronized input has held it for a programmable number of clocks. The decoder then compares the filtered phases with their values one clock earlier. It counts every phase edge, only edges of phase A, or only rising edges of phase A, depending on the resolution chosen.

The phase order sets the direction. When A leads B the count rises, and when B leads A it falls. The count wraps at the counter width. A sample in which both phases change together is illegal: it latches a sticky error flag and leaves the count and direction alone. When index reset is enabled, the rising edge of the filtered index clears the count. The block is used next to a motor or shaft sensor, and software reads the count and works out velocity from it.

Top module: `qdec_top`

## Requirements
- R1: While and after reset, `pos_count` is 0, `dir_up` is 1 and `err_flag` is 0.
- R2: With `mode_sel` = 2'b10 or 2'b11 (four counts per cycle), every accepted edge of A or of B moves the count by exactly one.
- R3: With `mode_sel` = 2'b01 (two counts per cycle), only accepted edges of A move the count, and edges of B leave it unchanged.
- R4: With `mode_sel` = 2'b00 (one count per cycle), only an accepted rising edge of A moves the count: up when B is low, down when B is high.
- R5: The (A,B) sequence 00, 10, 11, 01, 00 counts up and the reverse sequence counts down. After each counted step `dir_up` reads 1 for up and 0 for down, and it changes only on counted steps.
- R6: If A and B both change between two consecutive filtered samples, `err_flag` becomes 1 and stays 1 until reset, and the count and `dir_up` are unchanged by that sample.
- R7: The filter accepts a new level only after the synchronized input has shown it on `filt_len` consecutive clocks. A value of 0 acts as 1, and shorter pulses have no effect on the count.
- R8: If an input change is first sampled at rising edge k, the count reflects it after edge k + `filt_len` + SYNC_STAGES and not earlier (SYNC_STAGES = 2 by default).
- R9: When `idx_rst_en` is 1, an accepted rising edge of the index clears the count to 0, and this takes priority over a step in the same clock. When `idx_rst_en` is 0, the index has no effect on the count.
- R10: The count wraps modulo 2^CNT_W in both directions, so one step down from 0 gives all ones and one step up from all ones gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Resolution: 00 one, 01 two, 10/11 four counts per cycle |
| filt_len | input | FLT_W (4) | Clocks a new level must persist before it is accepted; 0 acts as 1 |
| idx_rst_en | input | 1 | Allow the index rising edge to clear the count |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_idx | input | 1 | Raw encoder index |
| pos_count | output | CNT_W (32) | Position count, two's complement |
| dir_up | output | 1 | Direction of the last counted step, 1 for up |
| err_flag | output | 1 | Sticky flag for an illegal double transition |

## Verification
The bench goes after pulses just shorter than the filter length. A filter that counts badly would let them through and produce a count it should not. It checks the exact clock on which a change first shows in the count, which catches a missing or extra pipeline stage. It also checks down steps in one-count mode, where a decoder that ignores B would count up instead of down. It steps down from zero and up from all ones, so a counter that saturates or clears at the wrap is exposed. The simultaneous change of both phases is tested to make sure it neither moves the count nor flips the direction, and that its flag survives later legal steps. The index is pulsed once with the enable off and once with it on, which shows whether the enable actually gates the clear.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   typedef enum logic [1:0] {
      QD_X1  = 2'b00,
      QD_X2  = 2'b01,
      QD_X4  = 2'b10,
      QD_X4B = 2'b11
   } qd_mode_e;

   typedef struct packed {
      logic inc;
      logic dec;
      logic bad;
   } qd_step_t;

   localparam int QD_CH_A   = 0;
   localparam int QD_CH_B   = 1;
   localparam int QD_CH_IDX = 2;
   localparam int QD_NCH    = 3;

endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FLT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic [FLT_W-1:0] len,
   output logic             level
);

   localparam int RUN_W = FLT_W + 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_lvl;
   logic [FLT_W-1:0]       run_q;
   logic [FLT_W-1:0]       need;
   logic [RUN_W-1:0]       run_next;

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], raw};
         end
      end else begin : g_syncn
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
         end
      end
   endgenerate

   assign sync_lvl = sync_q[SYNC_STAGES-1];
   assign need     = (len == '0) ? FLT_W'(1) : len;
   assign run_next = RUN_W'(run_q) + RUN_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         level <= 1'b0;
      end else if (sync_lvl == level) begin
         run_q <= '0;
      end else if (run_next >= RUN_W'(need)) begin
         level <= sync_lvl;
         run_q <= '0;
      end else begin
         run_q <= run_next[FLT_W-1:0];
      end
   end

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
   import qdec_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              idx_en,
   input  logic [QD_NCH-1:0] lvl,
   output qd_step_t          step,
   output logic              idx_zero
);

   logic [QD_NCH-1:0] prev_q;
   logic              ch_a, ch_b;
   logic              a_up, b_up;
   qd_mode_e          mode_e;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign mode_e = qd_mode_e'(mode);
   assign ch_a   = lvl[QD_CH_A] ^ prev_q[QD_CH_A];
   assign ch_b   = lvl[QD_CH_B] ^ prev_q[QD_CH_B];
   assign a_up   = lvl[QD_CH_A] != lvl[QD_CH_B];
   assign b_up   = lvl[QD_CH_B] == lvl[QD_CH_A];

   always_comb begin
      step = '0;
      if (ch_a && ch_b) begin
         step.bad = 1'b1;
      end else begin
         unique case (mode_e)
            QD_X1: begin
               if (ch_a && lvl[QD_CH_A]) begin
                  step.inc = ~lvl[QD_CH_B];
                  step.dec =  lvl[QD_CH_B];
               end
            end
            QD_X2: begin
               if (ch_a) begin
                  step.inc =  a_up;
                  step.dec = ~a_up;
               end
            end
            default: begin
               if (ch_a) begin
                  step.inc =  a_up;
                  step.dec = ~a_up;
               end else if (ch_b) begin
                  step.inc =  b_up;
                  step.dec = ~b_up;
               end
            end
         endcase
      end
   end

   assign idx_zero = idx_en & lvl[QD_CH_IDX] & ~prev_q[QD_CH_IDX];

endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
   import qdec_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  qd_step_t         step,
   input  logic             idx_zero,
   output logic [CNT_W-1:0] pos,
   output logic             dir_up,
   output logic             err
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos    <= '0;
         dir_up <= 1'b1;
         err    <= 1'b0;
      end else begin
         if (idx_zero)      pos <= '0;
         else if (step.inc) pos <= pos + ONE;
         else if (step.dec) pos <= pos - ONE;

         if (step.inc)      dir_up <= 1'b1;
         else if (step.dec) dir_up <= 1'b0;

         if (step.bad)      err <= 1'b1;
      end
   end

endmodule

// File: rtl/qdec_top.sv
module qdec_top
   import qdec_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int FLT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic [FLT_W-1:0] filt_len,
   input  logic             idx_rst_en,
   input  logic             enc_a,
   input  logic             enc_b,
   input  logic             enc_idx,
   output logic [CNT_W-1:0] pos_count,
   output logic             dir_up,
   output logic             err_flag
);

   generate
      if (CNT_W < 2) begin : g_chk_cnt
         $error("qdec_top: CNT_W must be at least 2");
      end
      if (FLT_W < 1 || FLT_W > 16) begin : g_chk_flt
         $error("qdec_top: FLT_W must lie in 1..16");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("qdec_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [QD_NCH-1:0] raw_w;
   logic [QD_NCH-1:0] lvl_w;
   qd_step_t          step_w;
   logic              idx_zero_w;

   assign raw_w[QD_CH_A]   = enc_a;
   assign raw_w[QD_CH_B]   = enc_b;
   assign raw_w[QD_CH_IDX] = enc_idx;

   for (genvar ch = 0; ch < QD_NCH; ch++) begin : g_in
      qdec_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FLT_W      (FLT_W)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .raw  (raw_w[ch]),
         .len  (filt_len),
         .level(lvl_w[ch])
      );
   end

   qdec_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_sel),
      .idx_en  (idx_rst_en),
      .lvl     (lvl_w),
      .step    (step_w),
      .idx_zero(idx_zero_w)
   );

   qdec_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step_w),
      .idx_zero(idx_zero_w),
      .pos     (pos_count),
      .dir_up  (dir_up),
      .err     (err_flag)
   );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             step_inc,
   input logic             step_dec,
   input logic             step_bad,
   input logic             idx_zero,
   input logic             lvl_a,
   input logic [CNT_W-1:0] pos_count,
   input logic             dir_up,
   input logic             err_flag
);

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   p_bad_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_bad && !idx_zero) |=> ($stable(pos_count) && $stable(dir_up) && err_flag));

   p_one_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({step_inc, step_dec, step_bad}));

   p_inc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step_inc && !idx_zero) |=> (pos_count == $past(pos_count) + 1'b1) && dir_up);

   p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dec && !idx_zero) |=> (pos_count == $past(pos_count) - 1'b1) && !dir_up);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_inc || step_dec || idx_zero) |=> $stable(pos_count));

   p_index_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idx_zero |=> (pos_count == '0));

   p_x1_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b00 && (step_inc || step_dec)) |-> lvl_a);

endmodule

bind qdec_top qdec_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .step_inc (step_w.inc),
   .step_dec (step_w.dec),
   .step_bad (step_w.bad),
   .idx_zero (idx_zero_w),
   .lvl_a    (lvl_w[0]),
   .pos_count(pos_count),
   .dir_up   (dir_up),
   .err_flag (err_flag)
);

// File: tb/sim_qdec_top.sv
module sim_qdec_top;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 32;
   localparam int FLT_W      = 4;
   localparam int SYNC       = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       mode_sel = 2'b10;
   logic [FLT_W-1:0] filt_len = 4'd1;
   logic             idx_rst_en = 1'b0;
   logic             enc_a = 1'b0;
   logic             enc_b = 1'b0;
   logic             enc_idx = 1'b0;
   logic [CNT_W-1:0] pos_count;
   logic             dir_up;
   logic             err_flag;

   int    n_chk  = 0;
   int    n_fail = 0;
   string tag    = "R1";
   int    g      = 0;

   qdec_top u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .filt_len  (filt_len),
      .idx_rst_en(idx_rst_en),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .enc_idx   (enc_idx),
      .pos_count (pos_count),
      .dir_up    (dir_up),
      .err_flag  (err_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference model
   logic [31:0] m_cnt;
   logic        m_dir, m_err;
   logic [2:0]  mf, mf_prev;
   logic [2:0]  hist[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_dir = 1; m_err = 0; mf = 0; mf_prev = 0;
         hist.delete();
      end else begin
         logic ca, cb, up, stepped;
         logic [2:0] nf;
         int L;
         ca = mf[0] ^ mf_prev[0];
         cb = mf[1] ^ mf_prev[1];
         stepped = 0; up = 0;
         if (ca && cb) m_err = 1;
         else if (mode_sel == 2'b00) begin
            if (ca && mf[0]) begin stepped = 1; up = !mf[1]; end
         end else if (mode_sel == 2'b01) begin
            if (ca) begin stepped = 1; up = (mf[0] != mf[1]); end
         end else begin
            if (ca) begin stepped = 1; up = (mf[0] != mf[1]); end
            else if (cb) begin stepped = 1; up = (mf[1] == mf[0]); end
         end
         if (stepped) m_dir = up;
         if (idx_rst_en && mf[2] && !mf_prev[2]) m_cnt = 0;
         else if (stepped) m_cnt = up ? m_cnt + 1 : m_cnt - 1;
         L = (filt_len == 0) ? 1 : int'(filt_len);
         nf = mf;
         for (int j = 0; j < 3; j++) begin
            if (hist.size() >= L + SYNC - 1) begin
               logic ok;
               ok = 1;
               for (int k = 0; k < L; k++)
                  if (hist[hist.size() - SYNC - k][j] == mf[j]) ok = 0;
               if (ok) nf[j] = !mf[j];
            end
         end
         mf_prev = mf;
         mf = nf;
         hist.push_back({enc_idx, enc_b, enc_a});
         if (hist.size() > 40) void'(hist.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk({tag, " count"}, pos_count, m_cnt);
         chk({tag, " dir"}, {31'b0, dir_up}, {31'b0, m_dir});
         chk({tag, " err"}, {31'b0, err_flag}, {31'b0, m_err});
      end
   end

   task automatic move(input int n, input int hold);
      int steps;
      steps = (n < 0) ? -n : n;
      for (int i = 0; i < steps; i++) begin
         g = (n > 0) ? (g + 1) % 4 : (g + 3) % 4;
         @(negedge clk);
         enc_a = (g == 1 || g == 2);
         enc_b = (g == 2 || g == 3);
         repeat (hold - 1) @(negedge clk);
      end
      repeat (24) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 count", pos_count, 32'd0);
      chk("R1 dir", {31'b0, dir_up}, 32'd1);
      chk("R1 err", {31'b0, err_flag}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 count after release", pos_count, 32'd0);

      tag = "R2"; mode_sel = 2'b10;
      move(12, 4);
      chk("R2 x4 up", pos_count, 32'd12);
      chk("R5 dir up", {31'b0, dir_up}, 32'd1);
      tag = "R5";
      move(-8, 4);
      chk("R2 x4 down", pos_count, 32'd4);
      chk("R5 dir down", {31'b0, dir_up}, 32'd0);
      tag = "R2"; mode_sel = 2'b11;
      move(4, 4);
      chk("R2 x4 alt code", pos_count, 32'd8);

      tag = "R3"; mode_sel = 2'b01;
      move(8, 4);
      chk("R3 x2 up", pos_count, 32'd12);
      move(-4, 4);
      chk("R3 x2 down", pos_count, 32'd10);

      tag = "R4"; mode_sel = 2'b00;
      move(8, 4);
      chk("R4 x1 up", pos_count, 32'd12);
      move(-8, 4);
      chk("R4 x1 down", pos_count, 32'd10);

      tag = "R7"; mode_sel = 2'b10; filt_len = 4'd5;
      repeat (4) @(negedge clk);
      enc_a = 1'b1;
      repeat (4) @(negedge clk);
      enc_a = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 short pulse ignored", pos_count, 32'd10);
      move(4, 8);
      chk("R7 long levels accepted", pos_count, 32'd14);
      filt_len = 4'd0;
      move(1, 2);
      chk("R7 length zero acts as one", pos_count, 32'd15);
      move(-1, 2);
      chk("R7 length zero back", pos_count, 32'd14);

      tag = "R8"; filt_len = 4'd3;
      repeat (4) @(negedge clk);
      g = 1;
      enc_a = 1'b1;
      repeat (3 + SYNC) @(negedge clk);
      chk("R8 not yet counted", pos_count, 32'd14);
      @(negedge clk);
      chk("R8 counted on time", pos_count, 32'd15);
      repeat (10) @(negedge clk);

      tag = "R9"; filt_len = 4'd1; idx_rst_en = 1'b0;
      enc_idx = 1'b1;
      repeat (4) @(negedge clk);
      enc_idx = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 index disabled", pos_count, 32'd15);
      idx_rst_en = 1'b1;
      enc_idx = 1'b1;
      repeat (4) @(negedge clk);
      enc_idx = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 index clears", pos_count, 32'd0);
      idx_rst_en = 1'b0;

      tag = "R10";
      move(-1, 4);
      chk("R10 wrap down", pos_count, 32'hFFFF_FFFF);
      move(1, 4);
      chk("R10 wrap up", pos_count, 32'd0);
      move(-2, 4);
      chk("R10 two below zero", pos_count, 32'hFFFF_FFFE);

      tag = "R6";
      @(negedge clk);
      enc_a = ~enc_a;
      enc_b = ~enc_b;
      g = (g + 2) % 4;
      repeat (12) @(negedge clk);
      chk("R6 error set", {31'b0, err_flag}, 32'd1);
      chk("R6 count held", pos_count, 32'hFFFF_FFFE);
      chk("R6 dir held", {31'b0, dir_up}, 32'd0);
      move(4, 4);
      chk("R6 count resumes", pos_count, 32'd2);
      chk("R6 error sticky", {31'b0, err_flag}, 32'd1);

      summary();
      $finish;
   end

endmodule